// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from reset to a usable state. Once reset is released it keeps the clock enable low and drives only no-operation commands for a stable-clock delay. That delay is given in microseconds and converted to clock cycles from the clock frequency parameter. The clock enable goes high halfway through the delay. When the delay ends, the block precharges all banks, issues two auto-refresh commands and loads the mode register. It then raises a ready flag that stays high until the next reset.

A parameter chooses whether the refresh pair comes before or after the mode-register load. The minimum gaps after a precharge, a refresh and a mode load are parameters counted in clock cycles. The sequencer fills each gap with no-operation commands. Every output is driven from a flop, so every pin changes only on the rising clock edge.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, the block drives: `cke` low, command `1111` (inhibit, `{cs_n,ras_n,cas_n,we_n}`), `addr` zero, `ba` zero and `init_done` low.
- R2: Let S = STABLE_US × CLK_MHZ. Counting edge 1 as the first rising edge with reset low, the command after each of edges 1 to S is NOP (`0111`), with `addr` and `ba` zero.
- R3: `cke` is high after edge S − S/2 and after every later edge, and low after every earlier edge.
- R4: After edge S+1, and only then, the command is PRECHARGE (`0010`) with `addr` bit 10 set, every other address bit clear and `ba` zero.
- R5: Apart from the commands placed by R4, R6 and R7, every edge after reset release yields NOP. The command after a precharge comes T_RP edges later, the command after a refresh comes T_RFC edges later, and the command after a mode load comes T_MRD edges later. Each timing parameter must be at least 2.
- R6: Exactly two AUTO REFRESH commands (`0001`, `addr` zero) are issued, T_RFC edges apart.
- R7: Exactly one LOAD MODE REGISTER command (`0000`) is issued. It carries `mode_val` on `addr` and zero on `ba`.
- R8: With REFRESH_FIRST = 1 the order after the precharge is refresh, refresh, mode load. With REFRESH_FIRST = 0 it is mode load, refresh, refresh.
- R9: `init_done` rises at the edge one gap (T_MRD or T_RFC, whichever belongs to the last command) after the last command. From then on it stays high and only NOPs follow, until reset.
- R10: Whenever `cke` is low, the command is NOP or inhibit.
- R11: Asserting reset partway through the sequence returns the block to its R1 state. After release, the whole sequence restarts from edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_val | input | ADDR_W | Value written to the mode register |
| cke | output | 1 | Clock enable to the device |
| cmd_n | output | 4 | Command `{cs_n, ras_n, cas_n, we_n}` |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| init_done | output | 1 | High once initialization is complete |

## Verification
All outputs are registered, so each result is due at a fixed edge number counted from reset release. The positions are S for the end of the NOP window, S − S/2 for the clock-enable rise, S+1 for the precharge, and then fixed gaps for the commands and for `init_done`. The bench derives these edge numbers from the parameters alone. It compares every output about 1 ns after every edge, so each command is checked in the single cycle in which it must appear and the NOP filling is checked in every other cycle. Two instances, one for each ordering, run in lock-step with several mode values, and one run is cut short by reset to check the restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_QUIET,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF_A,
        ST_WAIT_RFC_A,
        ST_REF_B,
        ST_WAIT_RFC_B,
        ST_LMR,
        ST_WAIT_MRD,
        ST_READY
    } step_e;

    typedef struct packed {
        logic cke;
        cmd_e cmd;
        logic done;
    } ctl_t;

    localparam int ALL_BANKS_BIT = 10;

    function automatic int us_to_cycles(input int us, input int mhz);
        return us * mhz;
    endfunction

    // Gap of t edges between commands: one command cycle plus (load+1) wait cycles.
    function automatic int gap_load(input int t);
        return (t > 2) ? t - 2 : 0;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_timer.sv
module init_timer #(
    parameter int W    = 8,
    parameter int INIT = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= W'(INIT);
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);

    // R5
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (count == $past(count) - 1'b1));

    // R5
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

endmodule

// File: rtl/init_fsm.sv
module init_fsm
    import sdram_init_pkg::*;
#(
    parameter int REFRESH_FIRST = 1,
    parameter int CW            = 8,
    parameter int HALF          = 5,
    parameter int T_RP          = 3,
    parameter int T_RFC         = 10,
    parameter int T_MRD         = 2,
    parameter int ADDR_W        = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_zero,
    input  logic [CW-1:0]     tmr_count,
    input  logic [ADDR_W-1:0] mode_val,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_val,
    output ctl_t              nxt_ctl,
    output logic [ADDR_W-1:0] nxt_addr
);

    localparam logic [CW-1:0] LD_RP  = CW'(gap_load(T_RP));
    localparam logic [CW-1:0] LD_RFC = CW'(gap_load(T_RFC));
    localparam logic [CW-1:0] LD_MRD = CW'(gap_load(T_MRD));
    localparam logic [CW-1:0] CKE_AT = CW'(HALF);

    step_e state, st_n;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_QUIET;
        else     state <= st_n;
    end

    always_comb begin
        st_n     = state;
        nxt_ctl  = '{cke: 1'b1, cmd: CMD_NOP, done: 1'b0};
        nxt_addr = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_QUIET: begin
                nxt_ctl.cke = (tmr_count <= CKE_AT);
                if (tmr_zero) st_n = ST_PRE;
            end
            ST_PRE: begin
                nxt_ctl.cmd             = CMD_PRE;
                nxt_addr[ALL_BANKS_BIT] = 1'b1;
                tmr_load                = 1'b1;
                tmr_val                 = LD_RP;
                st_n                    = ST_WAIT_RP;
            end
            ST_WAIT_RP: begin
                if (tmr_zero) begin
                    if (REFRESH_FIRST != 0) st_n = ST_REF_A;
                    else                    st_n = ST_LMR;
                end
            end
            ST_REF_A: begin
                nxt_ctl.cmd = CMD_REF;
                tmr_load    = 1'b1;
                tmr_val     = LD_RFC;
                st_n        = ST_WAIT_RFC_A;
            end
            ST_WAIT_RFC_A: begin
                if (tmr_zero) st_n = ST_REF_B;
            end
            ST_REF_B: begin
                nxt_ctl.cmd = CMD_REF;
                tmr_load    = 1'b1;
                tmr_val     = LD_RFC;
                st_n        = ST_WAIT_RFC_B;
            end
            ST_WAIT_RFC_B: begin
                if (tmr_zero) begin
                    if (REFRESH_FIRST != 0) st_n = ST_LMR;
                    else                    st_n = ST_READY;
                end
            end
            ST_LMR: begin
                nxt_ctl.cmd = CMD_LMR;
                nxt_addr    = mode_val;
                tmr_load    = 1'b1;
                tmr_val     = LD_MRD;
                st_n        = ST_WAIT_MRD;
            end
            ST_WAIT_MRD: begin
                if (tmr_zero) begin
                    if (REFRESH_FIRST != 0) st_n = ST_READY;
                    else                    st_n = ST_REF_A;
                end
            end
            ST_READY: begin
                nxt_ctl.done = 1'b1;
            end
            default: st_n = ST_QUIET;
        endcase
    end

    // R9
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY) |=> (state == ST_READY));

    // R5
    wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WAIT_RP || state == ST_WAIT_RFC_A || state == ST_WAIT_RFC_B
          || state == ST_WAIT_MRD) && tmr_zero) |=> (state != $past(state)));

    // R4
    quiet_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_QUIET && tmr_zero) |=> (state == ST_PRE));

endmodule

// File: rtl/cmd_outreg.sv
module cmd_outreg
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              nxt_ctl,
    input  logic [ADDR_W-1:0] nxt_addr,
    output logic              cke,
    output logic [3:0]        cmd_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cke   <= 1'b0;
            cmd_n <= CMD_INH;
            addr  <= '0;
            ba    <= '0;
            done  <= 1'b0;
        end else begin
            cke   <= nxt_ctl.cke;
            cmd_n <= nxt_ctl.cmd;
            addr  <= nxt_addr;
            ba    <= '0;
            done  <= nxt_ctl.done;
        end
    end

    // R10
    cke_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd_n == CMD_NOP || cmd_n == CMD_INH));

    // R4
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_n == CMD_PRE) |-> addr[ALL_BANKS_BIT]);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R9
    done_only_nop_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmd_n == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ       = 200,
    parameter int STABLE_US     = 100,
    parameter int T_RP          = 3,
    parameter int T_RFC         = 10,
    parameter int T_MRD         = 2,
    parameter int REFRESH_FIRST = 1,
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_val,
    output logic              cke,
    output logic [3:0]        cmd_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam int STABLE_CYC = us_to_cycles(STABLE_US, CLK_MHZ);
    localparam int HALF       = STABLE_CYC / 2;
    localparam int MAX_LOAD   = max_of(STABLE_CYC, max_of(T_RP, max_of(T_RFC, T_MRD)));
    localparam int CW         = $clog2(MAX_LOAD + 1);

    logic              tmr_zero;
    logic              tmr_load;
    logic [CW-1:0]     tmr_count;
    logic [CW-1:0]     tmr_val;
    ctl_t              nxt_ctl;
    logic [ADDR_W-1:0] nxt_addr;

    init_timer #(
        .W    (CW),
        .INIT (STABLE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero),
        .count    (tmr_count)
    );

    init_fsm #(
        .REFRESH_FIRST (REFRESH_FIRST),
        .CW            (CW),
        .HALF          (HALF),
        .T_RP          (T_RP),
        .T_RFC         (T_RFC),
        .T_MRD         (T_MRD),
        .ADDR_W        (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tmr_zero  (tmr_zero),
        .tmr_count (tmr_count),
        .mode_val  (mode_val),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .nxt_ctl   (nxt_ctl),
        .nxt_addr  (nxt_addr)
    );

    cmd_outreg #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .nxt_ctl  (nxt_ctl),
        .nxt_addr (nxt_addr),
        .cke      (cke),
        .cmd_n    (cmd_n),
        .addr     (addr),
        .ba       (ba),
        .done     (init_done)
    );

    // R9
    done_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |-> cke);

    // R3
    cke_stays_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

    localparam int CLK_MHZ = 200;
    localparam int ST_US   = 1;
    localparam int TRP     = 3;
    localparam int TRFC    = 7;
    localparam int TMRD    = 2;
    localparam int AW      = 13;
    localparam int BW      = 2;
    localparam int S       = ST_US * CLK_MHZ;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mode_val = '0;

    logic          cke_a, cke_b, done_a, done_b;
    logic [3:0]    cmd_a, cmd_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [BW-1:0] ba_a, ba_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(ST_US), .T_RP(TRP), .T_RFC(TRFC),
        .T_MRD(TMRD), .REFRESH_FIRST(1), .ADDR_W(AW), .BA_W(BW)
    ) dut (
        .clk(clk), .rst(rst), .mode_val(mode_val), .cke(cke_a), .cmd_n(cmd_a),
        .addr(addr_a), .ba(ba_a), .init_done(done_a)
    );

    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(ST_US), .T_RP(TRP), .T_RFC(TRFC),
        .T_MRD(TMRD), .REFRESH_FIRST(0), .ADDR_W(AW), .BA_W(BW)
    ) dut_lf (
        .clk(clk), .rst(rst), .mode_val(mode_val), .cke(cke_b), .cmd_n(cmd_b),
        .addr(addr_b), .ba(ba_b), .init_done(done_b)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected outputs at edge k after reset release, from the requirements alone.
    task automatic expect_at(input int k, input bit rf, input logic [AW-1:0] mode,
                             output logic [3:0] c, output logic [AW-1:0] a,
                             output logic ck, output logic dn, output string tag);
        int p, t1, t2, t3, td;
        p  = S + 1;
        t1 = p + TRP;
        if (rf) begin
            t2 = t1 + TRFC; t3 = t2 + TRFC; td = t3 + TMRD;
        end else begin
            t2 = t1 + TMRD; t3 = t2 + TRFC; td = t3 + TRFC;
        end
        c = 4'b0111; a = '0; ck = (k >= S - S / 2); dn = (k >= td); tag = "R5";
        if (k <= S)  tag = "R2";
        if (k == p) begin c = 4'b0010; a = AW'(1) << 10; tag = "R4"; end
        if (k == t1) begin
            c = rf ? 4'b0001 : 4'b0000; a = rf ? '0 : mode; tag = "R8";
        end
        if (k == t2) begin c = 4'b0001; tag = "R6"; end
        if (k == t3) begin
            c = rf ? 4'b0000 : 4'b0001; a = rf ? mode : '0; tag = rf ? "R7" : "R6";
        end
        if (k >= td) tag = "R9";
    endtask

    task automatic check_dut(input int k, input bit rf, input bit restart,
                             input logic [3:0] c, input logic [AW-1:0] a, input logic [BW-1:0] b,
                             input logic ck, input logic dn);
        logic [3:0]    ec;
        logic [AW-1:0] ea;
        logic          eck, edn;
        string         tg;
        expect_at(k, rf, mode_val, ec, ea, eck, edn, tg);
        if (restart && k <= 4) tg = "R11";
        check(tg, rf ? "cmd/addr/ba rf" : "cmd/addr/ba lf", {ec == 4'b0000 ? "L" : " ", c, a, b},
              {ec == 4'b0000 ? "L" : " ", ec, ea, {BW{1'b0}}});
        check(ck ? "R3" : "R10", "cke", {31'b0, ck}, {31'b0, eck});
        check("R9", "init_done", {31'b0, dn}, {31'b0, edn});
    endtask

    task automatic run_seq(input logic [AW-1:0] mode, input int ncyc, input bit restart);
        mode_val = mode;
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        // R1 reset state on both instances
        check(restart ? "R11" : "R1", "reset rf", {cke_a, cmd_a, addr_a, ba_a, done_a},
              {1'b0, 4'b1111, {AW{1'b0}}, {BW{1'b0}}, 1'b0});
        check(restart ? "R11" : "R1", "reset lf", {cke_b, cmd_b, addr_b, ba_b, done_b},
              {1'b0, 4'b1111, {AW{1'b0}}, {BW{1'b0}}, 1'b0});
        rst = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk); #1;
            check_dut(k, 1'b1, restart, cmd_a, addr_a, ba_a, cke_a, done_a);
            check_dut(k, 1'b0, restart, cmd_b, addr_b, ba_b, cke_b, done_b);
        end
    endtask

    initial begin
        run_seq(13'h0033, S + 40, 1'b0);
        run_seq(13'h1fff, S / 2 + 20, 1'b0);   // cut short by the next reset
        run_seq(13'h0a5a, S + 40, 1'b1);       // R11 restart after mid-sequence reset
        run_seq(13'h0000, S + 40, 1'b0);
        run_seq(13'h1555, S + 4, 1'b0);        // reset right after the precharge
        run_seq(13'h02c1, S + 40, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule